// File: doc/BRIEF.md
# Switchable Pipeline Hazard Interlock

This block is the stall and bubble controller for a five-stage integer pipeline (fetch, decode, execute, memory, write-back) that has no load instructions. It decodes the instruction word held in the decode stage and keeps a small shadow record of the destination registers of the two older instructions that have not yet written back, one in execute and one in memory. From the comparison between the decode-stage sources and that record it produces a hold for the program counter, a hold for the fetch/decode register, and a bubble request for the decode/execute register.

A mode input switches the unit at run time. With forwarding enabled, every producer is an ALU operation whose result can be forwarded after execute, so no stall is ever raised. With forwarding disabled, a dependent instruction waits in decode until its producer reaches write-back. Write-back is visible to a read in decode during the same cycle. A flush request from the branch logic overrides any stall and empties the shadow record of the instructions it discards. Forwarding multiplexers, the register file and branch resolution are outside the block.

Instruction fields: opcode in bits 31:26, first source `rs` in 25:21, second field `rt` in 20:16, `rd` in 15:11, function code in 5:0.

Top module: `hz_interlock`

## Requirements
- R1: Once reset is released, and before any instruction has passed decode, no hold is raised, even when decode holds an instruction with register sources.
- R2: Opcode 0x00 with function code 0x20, 0x24, 0x25 or 0x2A is a register-form ALU operation: it reads `rs` and `rt` and writes `rd`.
- R3: Opcodes 0x08, 0x0A, 0x0C and 0x0D are immediate-form ALU operations: they write `rt` and compare only `rs`, so a match on the `rt` field never stalls.
- R4: Opcodes 0x04 and 0x05 are branches: they compare both `rs` and `rt` and write no register, so a later reader of their operands never stalls because of them.
- R5: Register 0 never causes a hazard, neither as a source nor as a destination.
- R6: With forwarding off, a consumer directly behind its producer holds for exactly two cycles.
- R7: With forwarding off, a consumer two instructions behind its producer holds for exactly one cycle.
- R8: With forwarding off, a consumer three or more instructions behind its producer does not hold, because write-back and decode read share a cycle.
- R9: With forwarding on, no hold is raised for any instruction sequence.
- R10: A stall raises both holds and the bubble together. The bubble is low in a cycle with neither a stall nor a flush. A stalled instruction is neither lost nor duplicated as a producer when it advances.
- R11: A flush forces both holds low and the bubble high in the same cycle, and it clears the destinations in flight, so the next instruction in decode sees no hazard from them.
- R12: An empty decode slot (`id_valid_i` low) and any unlisted opcode read nothing and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fwd_en_i | input | 1 | 1 selects forwarding mode, 0 selects pure interlock |
| flush_i | input | 1 | Branch-taken flush from the branch logic |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_instr_i | input | 32 | Instruction word in decode |
| pc_hold_o | output | 1 | Keep the program counter |
| ifid_hold_o | output | 1 | Keep the fetch/decode register |
| idex_bubble_o | output | 1 | Load an empty slot into the decode/execute register |

## Verification
The hardest case to reach from the ports is a stalled instruction that is itself a producer. The stall must leave exactly one copy of that instruction's destination in the shadow record, and it must enter that record only in the cycle it leaves decode. The bench reaches this case with a three-instruction dependency chain in interlock mode and expects two separate two-cycle stalls. Beyond that case, it sweeps both modes, five producer kinds, seven consumer kinds and three distances, and derives each stall count from the distance.

// File: rtl/hz_interlock_pkg.sv
package hz_interlock_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  // stages whose result is not yet in the register file (EX, MEM)
  localparam int LIVE_STAGES = 2;
  // shadow slots emptied by a flush (new EX entry, discarded EX moving to MEM)
  localparam int FLUSH_REACH = 2;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_REG  = 2'd1,
    CLS_IMM  = 2'd2,
    CLS_BR   = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_interlock_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5
) (
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               use_rs_o,
  output logic               use_rt_o,
  output logic [REG_AW-1:0]  rs_o,
  output logic [REG_AW-1:0]  rt_o,
  output logic               wr_en_o,
  output logic [REG_AW-1:0]  wr_dst_o
);
  localparam int OP_LSB = INSTR_W - OP_W;
  localparam int RS_LSB = OP_LSB - REG_AW;
  localparam int RT_LSB = RS_LSB - REG_AW;
  localparam int RD_LSB = RT_LSB - REG_AW;

  logic [OP_W-1:0]   opcode;
  logic [FN_W-1:0]   funct;
  logic [REG_AW-1:0] rd;
  instr_cls_e        cls;
  logic              unused_shamt;

  assign opcode       = instr_i[INSTR_W-1:OP_LSB];
  assign funct        = instr_i[FN_W-1:0];
  assign rs_o         = instr_i[OP_LSB-1:RS_LSB];
  assign rt_o         = instr_i[RS_LSB-1:RT_LSB];
  assign rd           = instr_i[RT_LSB-1:RD_LSB];
  assign unused_shamt = ^instr_i[RD_LSB-1:FN_W];

  always_comb begin
    cls = CLS_NONE;
    unique case (opcode)
      OPC_REG: begin
        if (funct == FN_ADD || funct == FN_AND || funct == FN_OR || funct == FN_SLT)
          cls = CLS_REG;
      end
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI: cls = CLS_IMM;
      OPC_BEQ, OPC_BNE:                      cls = CLS_BR;
      default:                               cls = CLS_NONE;
    endcase
    if (!valid_i) cls = CLS_NONE;
  end

  assign use_rs_o = (cls != CLS_NONE);
  assign use_rt_o = (cls == CLS_REG) || (cls == CLS_BR);
  assign wr_en_o  = (cls == CLS_REG) || (cls == CLS_IMM);
  assign wr_dst_o = (cls == CLS_REG) ? rd : rt_o;
endmodule

// File: rtl/hz_track.sv
module hz_track
  import hz_interlock_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DEPTH  = LIVE_STAGES
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ins_vld_i,
  input  logic [REG_AW-1:0]            ins_dst_i,
  input  logic                         flush_i,
  output logic [DEPTH-1:0]             slot_vld_o,
  output logic [DEPTH-1:0][REG_AW-1:0] slot_dst_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic              nxt_vld;
    logic [REG_AW-1:0] nxt_dst;

    if (k == 0) begin : g_head
      assign nxt_vld = ins_vld_i;
      assign nxt_dst = ins_dst_i;
    end else begin : g_body
      assign nxt_vld = slot_vld_o[k-1];
      assign nxt_dst = slot_dst_o[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld_o[k] <= 1'b0;
        slot_dst_o[k] <= '0;
      end else begin
        slot_vld_o[k] <= (flush_i && (k < FLUSH_REACH)) ? 1'b0 : nxt_vld;
        slot_dst_o[k] <= nxt_dst;
      end
    end
  end
endmodule

// File: rtl/hz_compare.sv
module hz_compare #(
  parameter int REG_AW = 5,
  parameter int DEPTH  = 2
) (
  input  logic                         fwd_en_i,
  input  logic                         use_rs_i,
  input  logic [REG_AW-1:0]            rs_i,
  input  logic                         use_rt_i,
  input  logic [REG_AW-1:0]            rt_i,
  input  logic [DEPTH-1:0]             slot_vld_i,
  input  logic [DEPTH-1:0][REG_AW-1:0] slot_dst_i,
  output logic                         hazard_o
);
  logic             rs_live, rt_live;
  logic [DEPTH-1:0] hit;

  assign rs_live = use_rs_i && (rs_i != '0);
  assign rt_live = use_rt_i && (rt_i != '0);

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit[k] = slot_vld_i[k] &&
                    ((rs_live && slot_dst_i[k] == rs_i) ||
                     (rt_live && slot_dst_i[k] == rt_i));
  end

  // no loads: a forwarded ALU result always arrives in time
  assign hazard_o = !fwd_en_i && (|hit);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_interlock_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fwd_en_i,
  input  logic               flush_i,
  input  logic               id_valid_i,
  input  logic [INSTR_W-1:0] id_instr_i,
  output logic               pc_hold_o,
  output logic               ifid_hold_o,
  output logic               idex_bubble_o
);
  localparam int DEPTH = LIVE_STAGES;

  logic                         use_rs, use_rt, wr_en, stall;
  logic [REG_AW-1:0]            rs, rt, wr_dst;
  logic [DEPTH-1:0]             slot_vld;
  logic [DEPTH-1:0][REG_AW-1:0] slot_dst;

  hz_decode #(.INSTR_W(INSTR_W), .REG_AW(REG_AW)) u_dec (
    .valid_i  (id_valid_i),
    .instr_i  (id_instr_i),
    .use_rs_o (use_rs),
    .use_rt_o (use_rt),
    .rs_o     (rs),
    .rt_o     (rt),
    .wr_en_o  (wr_en),
    .wr_dst_o (wr_dst)
  );

  hz_compare #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_cmp (
    .fwd_en_i   (fwd_en_i),
    .use_rs_i   (use_rs),
    .rs_i       (rs),
    .use_rt_i   (use_rt),
    .rt_i       (rt),
    .slot_vld_i (slot_vld),
    .slot_dst_i (slot_dst),
    .hazard_o   (stall)
  );

  // an instruction enters EX only when it leaves ID unstalled and unflushed
  hz_track #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_vld_i  (wr_en && !stall && !flush_i),
    .ins_dst_i  (wr_dst),
    .flush_i    (flush_i),
    .slot_vld_o (slot_vld),
    .slot_dst_o (slot_dst)
  );

  assign pc_hold_o     = stall && !flush_i;
  assign ifid_hold_o   = stall && !flush_i;
  assign idex_bubble_o = stall || flush_i;
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fwd_en_i,
  input logic               flush_i,
  input logic               id_valid_i,
  input logic [INSTR_W-1:0] id_instr_i,
  input logic               pc_hold_o,
  input logic               ifid_hold_o,
  input logic               idex_bubble_o
);
  localparam int RS_LSB = INSTR_W - 6 - REG_AW;
  localparam int RT_LSB = RS_LSB - REG_AW;

  logic src_zero;
  logic unused_rest;
  assign src_zero    = (id_instr_i[INSTR_W-7:RT_LSB] == '0);
  assign unused_rest = ^{id_instr_i[INSTR_W-1:INSTR_W-6], id_instr_i[RT_LSB-1:0]};

  AST_HOLD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o == ifid_hold_o); // R10
  AST_HOLD_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> idex_bubble_o); // R10
  AST_FWD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_en_i |-> !pc_hold_o); // R9
  AST_FLUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!ifid_hold_o && idex_bubble_o)); // R11
  AST_FLUSH_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pc_hold_o); // R11
  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o && $past(pc_hold_o)) |=> !pc_hold_o); // R6
  AST_IDLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> !pc_hold_o); // R12
  AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_zero |-> !pc_hold_o); // R5
endmodule

bind hz_interlock hz_interlock_chk #(.INSTR_W(INSTR_W), .REG_AW(REG_AW)) u_chk (.*);

// File: tb/hz_interlock_tb_top.sv
module hz_interlock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_en = 1'b0;
  logic        flush = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic        pc_hold, ifid_hold, idex_bubble;
  int          n_checks = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  hz_interlock dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .fwd_en_i      (fwd_en),
    .flush_i       (flush),
    .id_valid_i    (id_valid),
    .id_instr_i    (id_instr),
    .pc_hold_o     (pc_hold),
    .ifid_hold_o   (ifid_hold),
    .idex_bubble_o (idex_bubble)
  );

  function automatic logic [31:0] rform(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, settle, outputs then readable
  task automatic put(input logic v, input logic [31:0] ins, input logic fl);
    @(negedge clk);
    id_valid = v;
    id_instr = ins;
    flush    = fl;
    #1;
  endtask

  task automatic drain();
    repeat (3) put(1'b0, 32'd0, 1'b0);
  endtask

  // stall cycles seen while cons waits in decode; bad counts R10 violations
  task automatic hold_run(input logic [31:0] cons, output int stalls, output int bad);
    stalls = 0;
    bad    = 0;
    put(1'b1, cons, 1'b0);
    while (pc_hold && stalls < 8) begin
      if (!idex_bubble || !ifid_hold) bad++;
      stalls++;
      put(1'b1, cons, 1'b0);
    end
    if (idex_bubble || ifid_hold) bad++;
  endtask

  task automatic run_case(input int mode, input int pk, input int ck, input int d);
    logic [4:0]  dreg;
    logic [31:0] prod, cons;
    logic        wr, dep;
    int          exp, stalls, bad;
    string       why, dtag;
    dreg = (pk == 3) ? 5'd0 : 5'd9;
    case (pk)
      0, 4:    prod = rform(6'h25, 5'd1, 5'd2, dreg);
      1:       prod = iform(6'h0D, 5'd1, dreg, 16'd5);
      2:       prod = iform(6'h04, dreg, dreg, 16'd0);
      default: prod = rform(6'h20, 5'd1, 5'd2, 5'd0);
    endcase
    case (ck)
      0:       cons = rform(6'h20, dreg, 5'd3, 5'd11);
      1:       cons = rform(6'h2A, 5'd3, dreg, 5'd11);
      2:       cons = iform(6'h08, dreg, 5'd4, 16'd1);
      3:       cons = iform(6'h0C, 5'd3, dreg, 16'd1);
      4:       cons = iform(6'h04, dreg, 5'd3, 16'd0);
      5:       cons = iform(6'h05, 5'd3, dreg, 16'd0);
      default: cons = iform(6'h23, dreg, dreg, 16'd0);
    endcase
    wr  = (pk == 0) || (pk == 1);
    dep = (ck != 3) && (ck != 6);
    exp = (mode == 0 && wr && dep && d < 3) ? 3 - d : 0;
    if (mode != 0)    why = "R9";
    else if (pk == 2) why = "R4";
    else if (pk == 3) why = "R5";
    else if (pk == 4) why = "R12";
    else if (ck == 3) why = "R3";
    else if (ck == 6) why = "R12";
    else if (ck >= 4) why = "R4";
    else if (ck == 2) why = "R3";
    else              why = "R2";
    dtag = (d == 1) ? "R6" : (d == 2) ? "R7" : "R8";
    fwd_en = (mode != 0);
    drain();
    put(pk != 4, prod, 1'b0);
    for (int f = 1; f < d; f++) put(1'b1, rform(6'h20, 5'd0, 5'd0, 5'(20 + f)), 1'b0);
    hold_run(cons, stalls, bad);
    check($sformatf("%s %s m%0d p%0d c%0d d%0d stalls", why, dtag, mode, pk, ck, d), stalls, exp);
    check($sformatf("R10 m%0d p%0d c%0d d%0d bubble/hold pairing", mode, pk, ck, d), bad, 0);
  endtask

  initial begin
    #(1_000_000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int s, b;
    id_valid = 1'b1;
    id_instr = rform(6'h20, 5'd9, 5'd9, 5'd11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: nothing in flight after reset
    check("R1 hold after reset", int'(pc_hold), 0);
    check("R1 bubble after reset", int'(idex_bubble), 0);
    put(1'b1, rform(6'h24, 5'd9, 5'd10, 5'd12), 1'b0);
    check("R1 second hold after reset", int'(ifid_hold), 0);

    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < 7; c++)
          for (int d = 1; d <= 3; d++)
            run_case(m, p, c, d);

    // R10: stalled instruction is itself a producer for the next one
    fwd_en = 1'b0;
    drain();
    put(1'b1, rform(6'h20, 5'd1, 5'd2, 5'd9), 1'b0);
    hold_run(rform(6'h20, 5'd9, 5'd0, 5'd11), s, b);
    check("R10 R6 chain first stalls", s, 2);
    check("R10 chain first pairing", b, 0);
    hold_run(iform(6'h0D, 5'd11, 5'd13, 16'd7), s, b);
    check("R10 R6 chain second stalls", s, 2);
    check("R10 chain second pairing", b, 0);
    hold_run(rform(6'h20, 5'd9, 5'd11, 5'd14), s, b);
    check("R10 R8 chain settled stalls", s, 0);

    // R11: flush beats a pending stall and empties the record
    drain();
    put(1'b1, rform(6'h20, 5'd1, 5'd2, 5'd9), 1'b0);
    put(1'b1, rform(6'h20, 5'd9, 5'd9, 5'd11), 1'b1);
    check("R11 flush hold", int'(pc_hold), 0);
    check("R11 flush ifid hold", int'(ifid_hold), 0);
    check("R11 flush bubble", int'(idex_bubble), 1);
    put(1'b1, rform(6'h20, 5'd9, 5'd9, 5'd11), 1'b0);
    check("R11 post-flush hold", int'(pc_hold), 0);
    // R11: flush two behind a producer already in MEM clears it too
    drain();
    put(1'b1, iform(6'h08, 5'd1, 5'd9, 16'd3), 1'b0);
    put(1'b1, rform(6'h20, 5'd0, 5'd0, 5'd21), 1'b1);
    check("R11 flush bubble idle", int'(idex_bubble), 1);
    put(1'b1, iform(6'h05, 5'd9, 5'd21, 16'd0), 1'b0);
    check("R11 post-flush branch hold", int'(pc_hold), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule